// File: doc/BRIEF.md
# Two-Bank Interrupt Request Controller

This block collects interrupt requests for a small 8-bit controller. It holds them in two request registers. Two enable registers mask those requests, and the result drives six individual interrupt lines into a CPU core. Software reaches the four registers through a 2-bit register select with a single-cycle write strobe and a read path with no wait states.

The high request bank follows three external interrupt lines. A rising line sets its bit and a falling line clears it. While a line holds steady, software may overwrite the bit. The low request bank takes one-cycle set strobes from three peripherals: serial receive, serial transmit and converter done. The converter may also clear its own bit through a separate clear strobe.

The two masked banks form a 16-bit pending word, with the high bank in the upper byte. Only six positions of that word reach the CPU lines. The block registers each of those six pending bits, so a line rises when its pending bit becomes 1 and falls when the bit becomes 0.

Top module: `irqc_top`

## Requirements
- R1: Select 0 is the high request bank, 1 the low request bank, 2 the high enable bank and 3 the low enable bank. With no line change and no strobe in the cycle, a write stores all 8 data bits. `rd_data` shows the selected register's current value in the same cycle, with no wait state.
- R2: External line k (k = 0, 1, 2) owns high request bit 2+k. In the cycle after a rising edge of the line, that bit reads 1. In the cycle after a falling edge it reads 0. A line edge takes priority over a software write in the same cycle. While the line is steady, a software write sets the bit.
- R3: The receive, transmit and converter-done set strobes force low request bits 3, 4 and 5 to 1. Each strobe takes priority over a software write in the same cycle. Bits without a strobe take the written value.
- R4: The converter clear strobe clears low request bit 5 and no other bit. A set strobe wins over a clear strobe in the same cycle, and a clear strobe wins over a software write.
- R5: The pending word is {high request AND high enable, low request AND low enable}. `irq_out[0..2]` follow pending bits 3, 4 and 5, and `irq_out[3..5]` follow pending bits 10, 11 and 12. Each output changes on the clock edge after the edge that changed its pending bit.
- R6: The ten other pending positions have no effect on `irq_out`, whatever the values of their request and enable bits.
- R7: Reset (active low, asynchronous) clears all four registers, the stored line levels and the stored pending bits, so `irq_out` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select (0..3) |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current value of the selected register |
| ext_line | input | 3 | External interrupt line levels |
| rx_set | input | 1 | Serial receive request strobe |
| tx_set | input | 1 | Serial transmit request strobe |
| adc_set | input | 1 | Converter-done request strobe |
| adc_clr | input | 1 | Converter request clear strobe |
| irq_out | output | 6 | Interrupt lines to the CPU core |

## Verification
The assertions assume that the external lines and strobes are synchronous to `clk` and change only between edges. They also assume that a set and a clear from the converter may coincide, and that peripheral strobes may overlap a software write. The bench changes every input on the falling edge and samples just after it. It drives the overlap cases on purpose: line edge with write, strobe with write, set with clear. Between those cases the lines stay constant, so that the register sweeps see only software writes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned REG_W    = 8;
   localparam int unsigned NUM_REGS = 4;
   localparam int unsigned SEL_W    = $clog2(NUM_REGS);
   localparam int unsigned NUM_OUT  = 6;

   typedef enum logic [1:0] {
      SEL_REQ_HI = 2'd0,
      SEL_REQ_LO = 2'd1,
      SEL_EN_HI  = 2'd2,
      SEL_EN_LO  = 2'd3
   } reg_sel_e;

   // pending-word position feeding CPU line idx: 3,4,5 then 10,11,12
   function automatic int unsigned line_src(input int unsigned idx);
      return (idx < 3) ? (3 + idx) : (7 + idx);
   endfunction
endpackage

// File: rtl/irqc_req_bank.sv
module irqc_req_bank #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic [W-1:0] set_vec,
   input  logic [W-1:0] clr_vec,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad_w
         $error("irqc_req_bank: W must be at least 1");
      end
   endgenerate

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic bit_q;
      // set over clear over software write
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          bit_q <= 1'b0;
         else if (set_vec[b]) bit_q <= 1'b1;
         else if (clr_vec[b]) bit_q <= 1'b0;
         else if (wr_en)      bit_q <= wr_data[b];
      end
      assign q[b] = bit_q;
   end
endmodule

// File: rtl/irqc_edge_track.sv
module irqc_edge_track #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] rise,
   output logic [N-1:0] fall
);
   logic [N-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;
endmodule

// File: rtl/irqc_out_map.sv
module irqc_out_map
   import irqc_pkg::*;
#(
   parameter int unsigned PEND_W = 16,
   parameter int unsigned N_OUT  = NUM_OUT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PEND_W-1:0] pending,
   output logic [N_OUT-1:0]  irq_out
);
   logic [N_OUT-1:0] taps;
   logic [N_OUT-1:0] prev_q;
   logic             unused_pend;

   for (genvar i = 0; i < N_OUT; i++) begin : g_tap
      if (line_src(i) >= PEND_W) begin : g_bad_tap
         $error("irqc_out_map: tap outside pending word");
      end else begin : g_ok_tap
         assign taps[i] = pending[line_src(i)];
      end
   end

   // stored previous pending bits: a 0->1 change raises, 1->0 drops
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= taps;
   end

   assign irq_out     = prev_q;
   assign unused_pend = ^pending;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
   import irqc_pkg::*;
#(
   parameter int unsigned DATA_W  = REG_W,
   parameter int unsigned NUM_EXT = 3,
   parameter int unsigned EXT_LSB = 2,
   parameter int unsigned RX_BIT  = 3,
   parameter int unsigned TX_BIT  = 4,
   parameter int unsigned ADC_BIT = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SEL_W-1:0]   reg_sel,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  rd_data,
   input  logic [NUM_EXT-1:0] ext_line,
   input  logic               rx_set,
   input  logic               tx_set,
   input  logic               adc_set,
   input  logic               adc_clr,
   output logic [NUM_OUT-1:0] irq_out
);
   localparam int unsigned PEND_W = 2 * DATA_W;

   generate
      if (EXT_LSB + NUM_EXT > DATA_W) begin : g_bad_ext
         $error("irqc_top: external bits exceed register width");
      end
      if (RX_BIT >= DATA_W || TX_BIT >= DATA_W || ADC_BIT >= DATA_W) begin : g_bad_per
         $error("irqc_top: peripheral bit outside register");
      end
      if (RX_BIT == TX_BIT || RX_BIT == ADC_BIT || TX_BIT == ADC_BIT) begin : g_bad_dup
         $error("irqc_top: peripheral bits must differ");
      end
   endgenerate

   logic [DATA_W-1:0]  req_hi_q, req_lo_q, en_hi_q, en_lo_q;
   logic [DATA_W-1:0]  set_hi, clr_hi, set_lo, clr_lo, zero_vec;
   logic [NUM_EXT-1:0] ext_rise, ext_fall;
   logic [PEND_W-1:0]  pending;
   logic               we_req_hi, we_req_lo, we_en_hi, we_en_lo;

   assign we_req_hi = wr_en && (reg_sel == SEL_REQ_HI);
   assign we_req_lo = wr_en && (reg_sel == SEL_REQ_LO);
   assign we_en_hi  = wr_en && (reg_sel == SEL_EN_HI);
   assign we_en_lo  = wr_en && (reg_sel == SEL_EN_LO);
   assign zero_vec  = '0;

   irqc_edge_track #(.N(NUM_EXT)) u_lines (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (ext_line),
      .rise (ext_rise),
      .fall (ext_fall)
   );

   always_comb begin
      set_hi = '0;
      clr_hi = '0;
      set_hi[EXT_LSB +: NUM_EXT] = ext_rise;
      clr_hi[EXT_LSB +: NUM_EXT] = ext_fall;
      set_lo = '0;
      clr_lo = '0;
      set_lo[RX_BIT]  = rx_set;
      set_lo[TX_BIT]  = tx_set;
      set_lo[ADC_BIT] = adc_set;
      clr_lo[ADC_BIT] = adc_clr;
   end

   irqc_req_bank #(.W(DATA_W)) u_req_hi (
      .clk(clk), .rst_n(rst_n), .wr_en(we_req_hi), .wr_data(wr_data),
      .set_vec(set_hi), .clr_vec(clr_hi), .q(req_hi_q)
   );
   irqc_req_bank #(.W(DATA_W)) u_req_lo (
      .clk(clk), .rst_n(rst_n), .wr_en(we_req_lo), .wr_data(wr_data),
      .set_vec(set_lo), .clr_vec(clr_lo), .q(req_lo_q)
   );
   irqc_req_bank #(.W(DATA_W)) u_en_hi (
      .clk(clk), .rst_n(rst_n), .wr_en(we_en_hi), .wr_data(wr_data),
      .set_vec(zero_vec), .clr_vec(zero_vec), .q(en_hi_q)
   );
   irqc_req_bank #(.W(DATA_W)) u_en_lo (
      .clk(clk), .rst_n(rst_n), .wr_en(we_en_lo), .wr_data(wr_data),
      .set_vec(zero_vec), .clr_vec(zero_vec), .q(en_lo_q)
   );

   always_comb begin
      unique case (reg_sel)
         SEL_REQ_HI: rd_data = req_hi_q;
         SEL_REQ_LO: rd_data = req_lo_q;
         SEL_EN_HI:  rd_data = en_hi_q;
         default:    rd_data = en_lo_q;
      endcase
   end

   assign pending = {req_hi_q & en_hi_q, req_lo_q & en_lo_q};

   irqc_out_map #(.PEND_W(PEND_W), .N_OUT(NUM_OUT)) u_map (
      .clk    (clk),
      .rst_n  (rst_n),
      .pending(pending),
      .irq_out(irq_out)
   );
endmodule

// File: rtl/irqc_checks.sv
module irqc_checks #(
   parameter int unsigned REG_W   = 8,
   parameter int unsigned NUM_EXT = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         reg_sel,
   input logic               wr_en,
   input logic [REG_W-1:0]   wr_data,
   input logic [NUM_EXT-1:0] ext_line,
   input logic               rx_set,
   input logic               adc_set,
   input logic               adc_clr,
   input logic [REG_W-1:0]   req_hi,
   input logic [REG_W-1:0]   req_lo,
   input logic [REG_W-1:0]   en_hi,
   input logic [REG_W-1:0]   en_lo,
   input logic [5:0]         irq_out
);
   logic [REG_W-1:0] m_hi, m_lo;
   logic [5:0]       exp_lines;
   assign m_hi      = req_hi & en_hi;
   assign m_lo      = req_lo & en_lo;
   assign exp_lines = {m_hi[4:2], m_lo[5:3]};

   p_en_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == 2'd2) |=> en_hi == $past(wr_data));

   for (genvar k = 0; k < NUM_EXT; k++) begin : g_line
      p_line_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ext_line[k]) |=> req_hi[2+k]);
      p_line_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(ext_line[k]) |=> !req_hi[2+k]);
   end

   p_rx_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_set |=> req_lo[3]);

   p_adc_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_clr && !adc_set) |=> !req_lo[5]);

   p_out_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == $past(exp_lines));

   p_reset_r7: assert property (@(posedge clk)
      !rst_n |-> (irq_out == '0 && req_hi == '0 && req_lo == '0
                  && en_hi == '0 && en_lo == '0));
endmodule

bind irqc_top irqc_checks #(.REG_W(DATA_W), .NUM_EXT(NUM_EXT)) u_checks (
   .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
   .wr_data(wr_data), .ext_line(ext_line), .rx_set(rx_set),
   .adc_set(adc_set), .adc_clr(adc_clr), .req_hi(req_hi_q),
   .req_lo(req_lo_q), .en_hi(en_hi_q), .en_lo(en_lo_q), .irq_out(irq_out)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_sel = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [2:0] ext_line = '0;
   logic       rx_set = 1'b0, tx_set = 1'b0, adc_set = 1'b0, adc_clr = 1'b0;
   logic [5:0] irq_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   irqc_top u_dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .ext_line(ext_line),
      .rx_set(rx_set), .tx_set(tx_set), .adc_set(adc_set),
      .adc_clr(adc_clr), .irq_out(irq_out)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic rd_chk(input logic [1:0] sel, input logic [7:0] exp, input string tag);
      reg_sel = sel;
      #1;
      chk(tag, rd_data, exp);
   endtask

   // write in one cycle; returns on the falling edge after the write edge
   task automatic wr(input logic [1:0] sel, input logic [7:0] d);
      @(negedge clk);
      reg_sel = sel; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic clear_all();
      for (int s = 0; s < 4; s++) wr(2'(s), 8'h00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] e;
      repeat (3) @(negedge clk);
      // R7: reset state
      for (int s = 0; s < 4; s++) rd_chk(2'(s), 8'h00, "R7 reset reg");
      chk("R7 reset irq", {2'b0, irq_out}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: exhaustive write/readback on every register
      for (int v = 0; v < 256; v++)
         for (int s = 0; s < 4; s++) begin
            wr(2'(s), 8'(v));
            rd_chk(2'(s), 8'(v), "R1 readback");
         end

      // R5: masking sweep, outputs one edge after the last write
      for (int v = 0; v < 256; v++) begin
         logic [7:0] rh, eh, rl, el, mh, ml;
         rh = ~8'(v); eh = 8'(v) ^ 8'h3C; rl = 8'(v); el = 8'(v) ^ 8'hA5;
         wr(2'd0, rh); wr(2'd2, eh); wr(2'd1, rl); wr(2'd3, el);
         @(negedge clk);
         mh = rh & eh; ml = rl & el;
         chk("R5 mask sweep", {2'b0, irq_out}, {2'b0, mh[4:2], ml[5:3]});
      end

      // R6: only unmapped positions requested and enabled
      wr(2'd0, 8'hFF); wr(2'd1, 8'hFF); wr(2'd2, 8'hE3); wr(2'd3, 8'hC7);
      @(negedge clk);
      chk("R6 unmapped bits", {2'b0, irq_out}, 8'h00);

      // R5: one-cycle lag of an output
      clear_all();
      wr(2'd3, 8'hFF);
      wr(2'd1, 8'h08);
      chk("R5 lag before", {2'b0, irq_out}, 8'h00);
      @(negedge clk);
      chk("R5 lag after", {2'b0, irq_out}, 8'h01);

      // R2: external lines
      clear_all();
      wr(2'd2, 8'hFF);
      ext_line = 3'b010;
      @(negedge clk);
      rd_chk(2'd0, 8'h08, "R2 line rise");
      chk("R2 irq before", {2'b0, irq_out}, 8'h00);
      @(negedge clk);
      chk("R2 irq line", {2'b0, irq_out}, 8'h10);
      wr(2'd0, 8'hFF);
      rd_chk(2'd0, 8'hFF, "R2 write while steady");
      ext_line = 3'b000;
      @(negedge clk);
      rd_chk(2'd0, 8'hF7, "R2 line fall");
      wr(2'd0, 8'h00);
      // line edge coincides with a write of zero
      @(negedge clk);
      reg_sel = 2'd0; wr_data = 8'h00; wr_en = 1'b1; ext_line = 3'b001;
      @(negedge clk);
      wr_en = 1'b0;
      rd_chk(2'd0, 8'h04, "R2 edge beats write");
      ext_line = 3'b000;
      @(negedge clk);
      rd_chk(2'd0, 8'h00, "R2 release");

      // R3: peripheral set strobes
      clear_all();
      @(negedge clk); rx_set = 1'b1;
      @(negedge clk); rx_set = 1'b0;
      rd_chk(2'd1, 8'h08, "R3 rx strobe");
      @(negedge clk);
      reg_sel = 2'd1; wr_data = 8'h00; wr_en = 1'b1; tx_set = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; tx_set = 1'b0;
      rd_chk(2'd1, 8'h10, "R3 strobe beats write");
      @(negedge clk); adc_set = 1'b1;
      @(negedge clk); adc_set = 1'b0;
      rd_chk(2'd1, 8'h30, "R3 adc strobe");

      // R4: converter clear
      @(negedge clk); adc_clr = 1'b1;
      @(negedge clk); adc_clr = 1'b0;
      rd_chk(2'd1, 8'h10, "R4 clear only bit5");
      @(negedge clk); adc_clr = 1'b1; adc_set = 1'b1;
      @(negedge clk); adc_clr = 1'b0; adc_set = 1'b0;
      rd_chk(2'd1, 8'h30, "R4 set beats clear");
      @(negedge clk);
      reg_sel = 2'd1; wr_data = 8'hFF; wr_en = 1'b1; adc_clr = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; adc_clr = 1'b0;
      rd_chk(2'd1, 8'hDF, "R4 clear beats write");

      // R7: reset mid-run
      for (int s = 0; s < 4; s++) wr(2'(s), 8'hFF);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      for (int s = 0; s < 4; s++) rd_chk(2'(s), 8'h00, "R7 mid-run reg");
      chk("R7 mid-run irq", {2'b0, irq_out}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      e = {2'b0, irq_out};
      chk("R7 after release", e, 8'h00);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule